// File: doc/BRIEF.md
# Dual-Section Synthesizer Power Sequencer

This block sequences power state and counter reset for the two phase-locked loop sections of a frequency synthesizer. The sections are called IF (index 0) and RF (index 1). A latch strobe captures each section's power-down bit, charge-pump three-state bit and a two-bit counter-reset code. The block then drives per-section control lines: charge-pump three-state enable, divider load/hold, and input-stage debias. It also drives one reference-oscillator enable that both sections share. Only the digital control is modelled.

A section can power down in one of two ways, and the choice depends on the three-state bit that was already held in the latch before the new strobe. If that bit was clear, the power-down is synchronous. The section first three-states its charge pump, then waits for its next phase-detector reference edge before it counts as powered down, so that no pump pulse is cut short. If that bit was already set, the power-down is asynchronous and completes at the strobe itself. Latching a 0 into the power-down bit restores normal operation at once.

Top module: `pll_pwr_seq`

## Requirements
- R1: The inputs `pd_bit`, `tri_bit` and `rst_mode` are captured only on a clock edge where `le` is 1 and `le` was 0 on the previous edge. At any other time, changes on these inputs have no effect on the outputs.
- R2: A section is UP and a strobe latches its power-down bit as 1 while its previously latched three-state bit is 0. That section's status moves to TRISTATING on the same edge. The status encodings are UP = 2'b00, TRISTATING = 2'b01, DOWN = 2'b10.
- R3: A TRISTATING section moves to DOWN on the first clock edge with its `ref_edge` bit high and no strobe. Until that edge it stays TRISTATING. A reference edge that comes on the strobe edge itself is not counted.
- R4: A section is UP and a strobe latches its power-down bit as 1 while its previously latched three-state bit is 1. That section goes directly to DOWN on the strobe edge.
- R5: A strobe that latches a 0 into a section's power-down bit returns that section to UP on the same edge, from any state. This holds even when a reference edge comes in that cycle. Strobes are accepted in every power state.
- R6: `cp_tri[s]` is high whenever section s has a latched three-state bit of 1, is not UP, or is in counter reset.
- R7: `div_load[s]` is high when section s is DOWN or in counter reset. `debias[s]` is high exactly when section s is DOWN.
- R8: In the latched counter-reset code, bit 0 resets IF and bit 1 resets RF, so code 2'b11 resets both sections. A reset section has `cp_tri` and `div_load` high without any change to its status.
- R9: `osc_en` is 0 only while both sections are DOWN.
- R10: After reset both sections are UP, all latched bits are 0, `cp_tri`, `div_load` and `debias` are 0, and `osc_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| le | input | 1 | Latch strobe; a rising level captures the control inputs |
| pd_bit | input | 2 | Power-down request per section (0 = IF, 1 = RF) |
| tri_bit | input | 2 | Charge-pump three-state request per section |
| rst_mode | input | 2 | Counter-reset code: bit 0 IF, bit 1 RF |
| ref_edge | input | 2 | Phase-detector reference edge pulse per section |
| cp_tri | output | 2 | Charge-pump three-state enable per section |
| div_load | output | 2 | R/N divider load/hold per section |
| debias | output | 2 | Input-stage debias flag per section |
| osc_en | output | 1 | Shared reference-oscillator enable |
| st_if | output | 2 | IF section status |
| st_rf | output | 2 | RF section status |

## Verification
Two events can land on the same clock edge: a strobe and a reference edge for a section. Two cases are driven on purpose. In the first, a section is UP and a strobe requests synchronous power-down while `ref_edge` is high; the section must stop at TRISTATING. In the second, a section is TRISTATING and a strobe releases power-down while `ref_edge` is high; the strobe must win, leaving the section UP. In both cases the status and control outputs are compared one cycle after the shared edge.

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       le,
  input  logic [1:0] pd_bit,
  input  logic [1:0] tri_bit,
  input  logic [1:0] rst_mode,
  input  logic [1:0] ref_edge,
  output logic [1:0] cp_tri,
  output logic [1:0] div_load,
  output logic [1:0] debias,
  output logic       osc_en,
  output logic [1:0] st_if,
  output logic [1:0] st_rf
);
  localparam logic [1:0] S_UP  = 2'b00;
  localparam logic [1:0] S_TRI = 2'b01;
  localparam logic [1:0] S_DN  = 2'b10;

  logic       le_q;
  logic       lat;
  logic [1:0] tri_q;
  logic [1:0] rm_q;
  logic [1:0] st [2];

  assign lat = le & ~le_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      le_q <= 1'b0;
      rm_q <= 2'b00;
    end else begin
      le_q <= le;
      if (lat) rm_q <= rst_mode;
    end

  for (genvar s = 0; s < 2; s++) begin : g_sec
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        tri_q[s] <= 1'b0;
        st[s]    <= S_UP;
      end else if (lat) begin
        tri_q[s] <= tri_bit[s];
        if (!pd_bit[s])        st[s] <= S_UP;
        else if (st[s] == S_UP) st[s] <= tri_q[s] ? S_DN : S_TRI;
      end else if (st[s] == S_TRI && ref_edge[s]) begin
        st[s] <= S_DN;
      end

    assign cp_tri[s]   = tri_q[s] | (st[s] != S_UP) | rm_q[s];
    assign div_load[s] = (st[s] == S_DN) | rm_q[s];
    assign debias[s]   = (st[s] == S_DN);
  end

  assign osc_en = ~((st[0] == S_DN) && (st[1] == S_DN));
  assign st_if  = st[0];
  assign st_rf  = st[1];
endmodule

module pll_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lat,
  input logic [1:0] pd_bit,
  input logic [1:0] tri_q,
  input logic [1:0] rst_mode,
  input logic [1:0] ref_edge,
  input logic [1:0] cp_tri,
  input logic [1:0] div_load,
  input logic [1:0] debias,
  input logic       osc_en,
  input logic [1:0] st_if,
  input logic [1:0] st_rf
);
  logic [1:0] sv [2];
  assign sv[0] = st_if;
  assign sv[1] = st_rf;

  for (genvar s = 0; s < 2; s++) begin : g_chk
    AST_SYNC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      lat && pd_bit[s] && !tri_q[s] && sv[s] == 2'b00 |=> sv[s] == 2'b01); // R2
    AST_TRI_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      sv[s] == 2'b01 && !lat && !ref_edge[s] |=> sv[s] == 2'b01); // R3
    AST_TRI_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      sv[s] == 2'b01 && !lat && ref_edge[s] |=> sv[s] == 2'b10); // R3
    AST_ASYNC_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      lat && pd_bit[s] && tri_q[s] && sv[s] == 2'b00 |=> sv[s] == 2'b10); // R4
    AST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      lat && !pd_bit[s] |=> sv[s] == 2'b00); // R5
    AST_CP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      sv[s] != 2'b00 |-> cp_tri[s]); // R6
    AST_DOWN_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
      sv[s] == 2'b10 |-> div_load[s] && debias[s]); // R7
    AST_CNT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      lat && rst_mode[s] |=> cp_tri[s] && div_load[s]); // R8
  end

  AST_OSC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> st_if == 2'b10 && st_rf == 2'b10); // R9
endmodule

bind pll_pwr_seq pll_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lat(lat), .pd_bit(pd_bit), .tri_q(tri_q),
  .rst_mode(rst_mode), .ref_edge(ref_edge), .cp_tri(cp_tri),
  .div_load(div_load), .debias(debias), .osc_en(osc_en),
  .st_if(st_if), .st_rf(st_rf)
);

// File: tb/test_pll_pwr_seq.sv
module test_pll_pwr_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       le = 1'b0;
  logic [1:0] pd_bit = '0, tri_bit = '0, rst_mode = '0, ref_edge = '0;
  logic [1:0] cp_tri, div_load, debias, st_if, st_rf;
  logic       osc_en;
  int         n_chk = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  pll_pwr_seq i_pll_pwr_seq (
    .clk(clk), .rst_n(rst_n), .le(le), .pd_bit(pd_bit), .tri_bit(tri_bit),
    .rst_mode(rst_mode), .ref_edge(ref_edge), .cp_tri(cp_tri),
    .div_load(div_load), .debias(debias), .osc_en(osc_en),
    .st_if(st_if), .st_rf(st_rf)
  );

  // stim: {le, pd[1:0], tri[1:0], rst_mode[1:0], ref[1:0]}
  // exp : {st_if, st_rf, cp_tri[1:0], div_load[1:0], debias[1:0], osc_en}
  localparam int NV = 27;
  localparam logic [19:0] VEC [NV] = '{
    {9'b0_00_00_00_00, 11'b00_00_00_00_00_1}, //  0 R10 idle
    {9'b1_01_00_00_00, 11'b01_00_01_00_00_1}, //  1 R2 sync entry IF
    {9'b0_01_00_00_00, 11'b01_00_01_00_00_1}, //  2 R3 waits
    {9'b0_01_00_00_01, 11'b10_00_01_01_01_1}, //  3 R3 ref edge
    {9'b1_01_11_00_00, 11'b10_00_11_01_01_1}, //  4 R6 RF tri latched
    {9'b0_11_11_00_00, 11'b10_00_11_01_01_1}, //  5 R1 no strobe
    {9'b1_11_11_00_00, 11'b10_10_11_11_11_0}, //  6 R4 async RF, R9 osc off
    {9'b0_11_11_00_00, 11'b10_10_11_11_11_0}, //  7 R9
    {9'b1_10_10_00_00, 11'b00_10_10_10_10_1}, //  8 R5 IF wake
    {9'b0_10_10_00_00, 11'b00_10_10_10_10_1}, //  9 R5
    {9'b1_01_01_00_00, 11'b01_00_01_00_00_1}, // 10 R2 prior tri rules
    {9'b0_01_01_00_11, 11'b10_00_01_01_01_1}, // 11 R3 per-section edge
    {9'b1_01_01_01_00, 11'b10_00_01_01_01_1}, // 12 R8
    {9'b0_01_01_01_00, 11'b10_00_01_01_01_1}, // 13 R8
    {9'b1_00_00_10_00, 11'b00_00_10_10_00_1}, // 14 R8 RF reset
    {9'b0_00_00_10_00, 11'b00_00_10_10_00_1}, // 15 R8
    {9'b1_00_00_11_00, 11'b00_00_11_11_00_1}, // 16 R8 both
    {9'b0_00_00_11_00, 11'b00_00_11_11_00_1}, // 17 R8
    {9'b1_00_00_00_00, 11'b00_00_00_00_00_1}, // 18 R7 release
    {9'b0_00_00_00_00, 11'b00_00_00_00_00_1}, // 19 R1
    {9'b1_01_00_00_01, 11'b01_00_01_00_00_1}, // 20 R3 strobe edge ref ignored
    {9'b0_01_00_00_00, 11'b01_00_01_00_00_1}, // 21 R3
    {9'b1_00_00_00_01, 11'b00_00_00_00_00_1}, // 22 R5 strobe beats ref
    {9'b0_00_00_00_00, 11'b00_00_00_00_00_1}, // 23 R1
    {9'b1_00_00_01_00, 11'b00_00_01_01_00_1}, // 24 R8 IF reset
    {9'b0_00_00_01_00, 11'b00_00_01_01_00_1}, // 25 R8
    {9'b1_00_00_00_00, 11'b00_00_00_00_00_1}  // 26 R7
  };

  function automatic string tag(input int i);
    case (i)
      0:                  return "R10";
      1, 10:              return "R2";
      2, 3, 11, 20, 21:   return "R3";
      4:                  return "R6";
      5, 19, 23:          return "R1";
      6:                  return "R4";
      7:                  return "R9";
      8, 9, 22:           return "R5";
      18, 26:             return "R7";
      default:            return "R8";
    endcase
  endfunction

  function automatic logic [10:0] obs();
    return {st_if, st_rf, cp_tri, div_load, debias, osc_en};
  endfunction

  task automatic check(input string rq, input logic [10:0] exp);
    n_chk++;
    if (obs() !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", rq, obs(), exp);
    end
  endtask

  task automatic drive(input logic [8:0] s);
    {le, pd_bit, tri_bit, rst_mode, ref_edge} = s;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", 11'b00_00_00_00_00_1);
    rst_n = 1'b1;
    drive(VEC[0][19:11]);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check(tag(i), VEC[i][10:0]);
      if (i + 1 < NV) drive(VEC[i + 1][19:11]);
    end

    // R4 both async, then R10 reset mid power-down
    drive(9'b0_00_11_00_00);
    @(negedge clk);
    drive(9'b1_00_11_00_00);
    @(negedge clk);
    drive(9'b0_00_11_00_00);
    @(negedge clk);
    drive(9'b1_11_11_00_00);
    @(negedge clk);
    check("R4", 11'b10_10_11_11_11_0);
    drive(9'b0_11_11_00_11);
    @(negedge clk);
    check("R9", 11'b10_10_11_11_11_0);
    rst_n = 1'b0;
    #1;
    check("R10", 11'b00_00_00_00_00_1);
    @(negedge clk);
    rst_n = 1'b1;
    drive(9'b0_00_00_00_00);
    @(negedge clk);
    check("R10", 11'b00_00_00_00_00_1);
    finish_run();
  end
endmodule